// File: doc/BRIEF.md
# Supervisor Reset and Power-Fail Interrupt Timing Core

This block holds the digital timing of a microprocessor supervisor. Three comparator-style inputs come in, already synchronized to the clock: a flag that the supply is below its trip level, a flag that a user-chosen sense node is below its threshold, and an active-low pushbutton. The block drives a reset pair made of an active-high and an active-low output, plus an active-low non-maskable interrupt that warns the processor early of a coming power loss.

All timing follows a one-cycle clock-enable tick, and each time span is a parameter given in ticks. A persistence filter on each input ignores short glitches. A pushbutton press counts only after the button has stayed low for a debounce period. One shared stretcher holds the reset active while any qualified fault is present. It then keeps the reset active for a fixed hold time that starts when the last fault goes away, so for the button the hold time starts at release. The interrupt fires once for each qualified sense-low event and always has at least a minimum width. It cannot start while the supply itself is qualified as low, as happens during power-up.

Top module: `supv_core`

## Requirements
- R1: While `rst_i` is high and in the cycle after it, `rst_o` is 1, `rst_n_o` is 0 and `nmi_n_o` is 1.
- R2: When `vcc_low_i` stays 1 for GLITCH_TICKS ticks in a row, `rst_o` becomes 1 on the following clock edge.
- R3: A `vcc_low_i` pulse shorter than GLITCH_TICKS ticks does not assert reset.
- R4: When no fault remains, reset stays active for exactly HOLD_TICKS more ticks and then drops. `rst_n_o` is always the complement of `rst_o`.
- R5: A press (`pb_n_i` = 0) asserts reset only after PB_DEBOUNCE_TICKS ticks of stable low. A shorter press is ignored.
- R6: Reset stays active for as long as the button is held, and the HOLD_TICKS hold time counts from the release.
- R7: A sense-low (`sense_low_i` = 1) that lasts SENSE_FILTER_TICKS ticks drives `nmi_n_o` to 0 on the next edge, for exactly NMI_PULSE_TICKS ticks, even if the sense input recovers during the pulse.
- R8: A sense-low shorter than SENSE_FILTER_TICKS ticks produces no interrupt.
- R9: One sense-low event gives exactly one pulse. A new pulse needs `sense_low_i` to return to 0 first.
- R10: While the supply is qualified low, no interrupt pulse can start. If the sense input is still low when the supply recovers, the pulse starts two edges after recovery.
- R11: While `tick_i` is 0, the hold and pulse timers do not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high block reset |
| tick_i | input | 1 | Clock enable that advances every timer |
| vcc_low_i | input | 1 | Supply comparator: 1 means below trip |
| sense_low_i | input | 1 | Sense comparator: 1 means below threshold |
| pb_n_i | input | 1 | Pushbutton, 0 means pressed |
| rst_o | output | 1 | Reset, active high |
| rst_n_o | output | 1 | Reset, active low |
| nmi_n_o | output | 1 | Power-fail interrupt, active low |

## Verification
The bench aims at the filter boundaries: dips one tick shorter than each persistence window must leave the outputs alone, and a filter that counts one tick too few would instead reset the processor on supply noise. The hold interval is measured from the button release and from the supply recovery, with the tick held low partway through. A stretcher started at the press, or one that ignores the enable, would release early or late. On the interrupt, the bench holds the sense low for far longer than a pulse, drops it in the middle of a pulse, and raises it together with the supply. This exposes retriggering, pulses cut short, and interrupts that escape during power-up.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Input channel indices into the qualified-flag vector
    localparam int CH_SUPPLY = 0;
    localparam int CH_BUTTON = 1;
    localparam int CH_SENSE  = 2;
    localparam int N_CH      = 3;

    // Reset stretcher states
    typedef enum logic [1:0] {
        RS_RUN   = 2'd0,
        RS_FAULT = 2'd1,
        RS_HOLD  = 2'd2
    } rs_state_e;

    // Interrupt sequencer states
    typedef enum logic [1:0] {
        NM_IDLE  = 2'd0,
        NM_PULSE = 2'd1,
        NM_SPENT = 2'd2
    } nm_state_e;

    // Bits needed to hold values 0..n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/supv_persist.sv
module supv_persist
    import supv_pkg::*;
#(
    parameter int unsigned LEN     = 4,
    parameter bit          INIT_ON = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic raw_i,
    output logic qual_o
);
    localparam int W = cnt_bits(int'(LEN));
    localparam logic [W-1:0] CMAX = W'(LEN);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    // Qualify after LEN ticks of continuous assertion; drop at once on release
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= INIT_ON ? CMAX : '0;
            qual_o <= INIT_ON;
        end else if (!raw_i) begin
            cnt_q  <= '0;
            qual_o <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q != CMAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (cnt_q >= LAST) begin
                qual_o <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
    import supv_pkg::*;
#(
    parameter int unsigned HOLD = 24
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic fault_i,
    output logic active_o
);
    localparam int W = cnt_bits(int'(HOLD));
    localparam logic [W-1:0] LAST = W'(HOLD - 1);

    rs_state_e    st_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= RS_FAULT;
            cnt_q <= '0;
        end else if (fault_i) begin
            st_q  <= RS_FAULT;
            cnt_q <= '0;
        end else if (st_q != RS_RUN && tick_i) begin
            if (cnt_q == LAST) begin
                st_q  <= RS_RUN;
                cnt_q <= '0;
            end else begin
                st_q  <= RS_HOLD;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign active_o = (st_q != RS_RUN);

endmodule

// File: rtl/supv_nmi.sv
module supv_nmi
    import supv_pkg::*;
#(
    parameter int unsigned PULSE = 12
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic sense_i,
    input  logic arm_i,
    output logic active_o
);
    localparam int W = cnt_bits(int'(PULSE));
    localparam logic [W-1:0] LAST = W'(PULSE - 1);

    nm_state_e    st_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= NM_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                NM_IDLE: begin
                    if (sense_i && arm_i) begin
                        st_q  <= NM_PULSE;
                        cnt_q <= '0;
                    end
                end
                NM_PULSE: begin
                    if (tick_i) begin
                        if (cnt_q == LAST) begin
                            st_q  <= sense_i ? NM_SPENT : NM_IDLE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                NM_SPENT: begin
                    if (!sense_i) begin
                        st_q <= NM_IDLE;
                    end
                end
                default: st_q <= NM_IDLE;
            endcase
        end
    end

    assign active_o = (st_q == NM_PULSE);

endmodule

// File: rtl/supv_core.sv
module supv_core
    import supv_pkg::*;
#(
    parameter int unsigned GLITCH_TICKS       = 2,
    parameter int unsigned PB_DEBOUNCE_TICKS  = 10000,
    parameter int unsigned HOLD_TICKS         = 130000,
    parameter int unsigned SENSE_FILTER_TICKS = 5,
    parameter int unsigned NMI_PULSE_TICKS    = 200
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    input  logic vcc_low_i,
    input  logic sense_low_i,
    input  logic pb_n_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic nmi_n_o
);
    localparam int unsigned CH_LEN [N_CH] =
        '{GLITCH_TICKS, PB_DEBOUNCE_TICKS, SENSE_FILTER_TICKS};

    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] qual;
    logic            rst_active;
    logic            nmi_active;

    assign raw[CH_SUPPLY] = vcc_low_i;
    assign raw[CH_BUTTON] = ~pb_n_i;
    assign raw[CH_SENSE]  = sense_low_i;

    // One persistence filter per input; the supply starts out as low
    for (genvar c = 0; c < N_CH; c++) begin : g_filt
        supv_persist #(
            .LEN     (CH_LEN[c]),
            .INIT_ON (1'(c == CH_SUPPLY))
        ) u_filt (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .tick_i (tick_i),
            .raw_i  (raw[c]),
            .qual_o (qual[c])
        );
    end

    supv_stretch #(
        .HOLD (HOLD_TICKS)
    ) u_stretch (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .fault_i  (qual[CH_SUPPLY] | qual[CH_BUTTON]),
        .active_o (rst_active)
    );

    supv_nmi #(
        .PULSE (NMI_PULSE_TICKS)
    ) u_nmi (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .tick_i   (tick_i),
        .sense_i  (qual[CH_SENSE]),
        .arm_i    (~qual[CH_SUPPLY]),
        .active_o (nmi_active)
    );

    assign rst_o   = rst_active;
    assign rst_n_o = ~rst_active;
    assign nmi_n_o = ~nmi_active;

endmodule

// File: rtl/supv_core_chk.sv
module supv_core_chk
    import supv_pkg::*;
(
    input logic            clk_i,
    input logic            rst_i,
    input logic            tick_i,
    input logic [N_CH-1:0] qual_i,
    input logic            rst_o,
    input logic            rst_n_o,
    input logic            nmi_n_o
);
    // R2: a qualified supply or button fault forces reset next cycle
    a_r2_fault_forces_reset: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_i[CH_SUPPLY] || qual_i[CH_BUTTON]) |=> rst_o);

    // R4: reset is released only after a cycle with no qualified fault
    a_r4_release_after_clear: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(rst_n_o) |-> $past(!qual_i[CH_SUPPLY] && !qual_i[CH_BUTTON]));

    // R7: an interrupt begins only from a qualified sense-low
    a_r7_nmi_from_sense: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(nmi_n_o) |-> $past(qual_i[CH_SENSE]));

    // R7: the pulse is never a single cycle
    a_r7_min_width: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(nmi_n_o) |=> !nmi_n_o);

    // R10: no pulse can start while the supply is qualified low
    a_r10_gated_by_supply: assert property (@(posedge clk_i) disable iff (rst_i)
        (qual_i[CH_SUPPLY] && nmi_n_o) |=> nmi_n_o);

    // R11: without a tick the reset hold cannot expire
    a_r11_tick_freeze: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && rst_o) |=> rst_o);

endmodule

bind supv_core supv_core_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .qual_i  (qual),
    .rst_o   (rst_o),
    .rst_n_o (rst_n_o),
    .nmi_n_o (nmi_n_o)
);

// File: tb/supv_core_tb_top.sv
module supv_core_tb_top;
    localparam int G = 4;
    localparam int D = 6;
    localparam int H = 24;
    localparam int F = 5;
    localparam int P = 12;

    logic clk = 1'b0;
    logic rst_i = 1'b1;
    logic tick_i = 1'b1;
    logic vcc_low_i = 1'b1;
    logic sense_low_i = 1'b0;
    logic pb_n_i = 1'b1;
    logic rst_o, rst_n_o, nmi_n_o;

    always #4 clk = ~clk;

    supv_core #(
        .GLITCH_TICKS       (G),
        .PB_DEBOUNCE_TICKS  (D),
        .HOLD_TICKS         (H),
        .SENSE_FILTER_TICKS (F),
        .NMI_PULSE_TICKS    (P)
    ) dut_i (
        .clk_i       (clk),
        .rst_i       (rst_i),
        .tick_i      (tick_i),
        .vcc_low_i   (vcc_low_i),
        .sense_low_i (sense_low_i),
        .pb_n_i      (pb_n_i),
        .rst_o       (rst_o),
        .rst_n_o     (rst_n_o),
        .nmi_n_o     (nmi_n_o)
    );

    typedef struct {
        int    due;
        string tag;
        bit    exp_rst;
        bit    exp_nmi;
    } item_t;

    item_t sb_q[$];
    item_t cur;
    int    cyc = 0;
    int    mark = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare scoreboard items when their cycle comes up
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            cur = sb_q.pop_front();
            checks++;
            if (cur.due != cyc || rst_o !== cur.exp_rst || rst_n_o !== !cur.exp_rst
                || nmi_n_o !== !cur.exp_nmi) begin
                errors++;
                $display("FAIL %s at cycle %0d (due %0d): actual rst_o=%b rst_n_o=%b nmi_n_o=%b expected rst_o=%b rst_n_o=%b nmi_n_o=%b",
                         cur.tag, cyc, cur.due, rst_o, rst_n_o, nmi_n_o,
                         cur.exp_rst, !cur.exp_rst, !cur.exp_nmi);
            end
        end
    end

    task automatic anchor();
        mark = cyc;
    endtask

    task automatic expect_at(input int k, input string tag, input bit r, input bit n);
        item_t it;
        it.due = mark + k;
        it.tag = tag;
        it.exp_rst = r;
        it.exp_nmi = n;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        step(3);
        // R1: reset state
        anchor();
        expect_at(1, "R1 reset state", 1'b1, 1'b0);
        drain();

        // R4: power-up hold after supply is good
        rst_i = 1'b0; vcc_low_i = 1'b0; anchor();
        expect_at(H,     "R4 power-up hold",    1'b1, 1'b0);
        expect_at(H + 1, "R4 power-up release", 1'b0, 1'b0);
        drain(); step(2);

        // R3: supply dip one tick short
        vcc_low_i = 1'b1; anchor();
        expect_at(G,     "R3 short dip ignored", 1'b0, 1'b0);
        expect_at(G + 4, "R3 short dip ignored", 1'b0, 1'b0);
        step(G - 1); vcc_low_i = 1'b0;
        drain(); step(2);

        // R2 and R4: qualified supply fault, then hold
        vcc_low_i = 1'b1; anchor();
        expect_at(G,     "R2 before qualify",             1'b0, 1'b0);
        expect_at(G + 1, "R2 supply fault asserts reset", 1'b1, 1'b0);
        step(G + 10);
        vcc_low_i = 1'b0; anchor();
        expect_at(H,     "R4 hold after supply",    1'b1, 1'b0);
        expect_at(H + 1, "R4 release after supply", 1'b0, 1'b0);
        drain(); step(2);

        // R5: short press
        pb_n_i = 1'b0; anchor();
        expect_at(D,     "R5 short press ignored", 1'b0, 1'b0);
        expect_at(D + 4, "R5 short press ignored", 1'b0, 1'b0);
        step(D - 1); pb_n_i = 1'b1;
        drain(); step(2);

        // R5 and R6: long press, hold from release
        pb_n_i = 1'b0; anchor();
        expect_at(D,      "R5 before debounce",    1'b0, 1'b0);
        expect_at(D + 1,  "R5 debounced press",    1'b1, 1'b0);
        expect_at(H + 10, "R6 held while pressed", 1'b1, 1'b0);
        expect_at(2 * H,  "R6 held while pressed", 1'b1, 1'b0);
        step(2 * H + 5);
        pb_n_i = 1'b1; anchor();
        expect_at(H,     "R6 hold counts from release", 1'b1, 1'b0);
        expect_at(H + 1, "R6 release",                  1'b0, 1'b0);
        drain(); step(2);

        // R8: short sense dip
        sense_low_i = 1'b1; anchor();
        expect_at(F,     "R8 short sense dip ignored", 1'b0, 1'b0);
        expect_at(F + 4, "R8 short sense dip ignored", 1'b0, 1'b0);
        step(F - 1); sense_low_i = 1'b0;
        drain(); step(2);

        // R7: qualified sense-low, sense recovers mid-pulse
        sense_low_i = 1'b1; anchor();
        expect_at(F,         "R7 before filter",       1'b0, 1'b0);
        expect_at(F + 1,     "R7 nmi asserted",        1'b0, 1'b1);
        expect_at(F + P,     "R7 full width kept",     1'b0, 1'b1);
        expect_at(F + P + 1, "R7 nmi released",        1'b0, 1'b0);
        step(F + 2); sense_low_i = 1'b0;
        drain(); step(2);

        // R9: one pulse per event
        sense_low_i = 1'b1; anchor();
        expect_at(F + 1,         "R9 first pulse",        1'b0, 1'b1);
        expect_at(F + P + 1,     "R9 first pulse ends",   1'b0, 1'b0);
        expect_at(F + 2 * P + 5, "R9 no repeat",          1'b0, 1'b0);
        step(F + 2 * P + 8);
        sense_low_i = 1'b0; step(3);
        sense_low_i = 1'b1; anchor();
        expect_at(F + 1,     "R9 new event fires",  1'b0, 1'b1);
        expect_at(F + P + 1, "R9 second pulse ends", 1'b0, 1'b0);
        drain();
        sense_low_i = 1'b0; step(3);

        // R10: interrupt gated while supply is low
        vcc_low_i = 1'b1; sense_low_i = 1'b1; anchor();
        expect_at(G + 1,  "R10 supply fault reset", 1'b1, 1'b0);
        expect_at(F + 1,  "R10 nmi gated",          1'b1, 1'b0);
        expect_at(F + 10, "R10 nmi gated",          1'b1, 1'b0);
        step(30);
        vcc_low_i = 1'b0; anchor();
        expect_at(1,     "R10 still gated",           1'b1, 1'b0);
        expect_at(2,     "R10 fires after recovery",  1'b1, 1'b1);
        expect_at(P + 1, "R10 pulse width",           1'b1, 1'b1);
        expect_at(P + 2, "R10 pulse ends",            1'b1, 1'b0);
        expect_at(H + 1, "R4 release after recovery", 1'b0, 1'b0);
        drain();
        sense_low_i = 1'b0; step(3);

        // R11: timers frozen without tick
        vcc_low_i = 1'b1; anchor();
        expect_at(G + 1, "R11 fault asserted", 1'b1, 1'b0);
        step(G + 3);
        vcc_low_i = 1'b0; tick_i = 1'b0; anchor();
        expect_at(H + 5, "R11 hold frozen", 1'b1, 1'b0);
        expect_at(2 * H, "R11 hold frozen", 1'b1, 1'b0);
        step(3 * H);
        tick_i = 1'b1; anchor();
        expect_at(H - 1, "R11 hold resumes",         1'b1, 1'b0);
        expect_at(H,     "R11 release after ticks",  1'b0, 1'b0);
        drain(); step(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=still running expected=finished (all requirements)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule